// File: doc/BRIEF.md
# Highway and Farm-Road Junction Light Sequencer

This block runs the signal lights where a busy highway meets a minor farm road. A single car-waiting input, already synchronised to the clock, comes from a detector at the farm road stop line. The block drives one two-bit colour code for each road. The highway is favoured. It holds green for a minimum time and then keeps green until a farm-road car is waiting. The farm road then gets green only while cars keep arriving, and never for longer than the long interval.

Internally, a four-phase cyclic counter chooses the phase and two colour decoders turn the phase into lights. A retriggerable interval timer gives the counter two expiry flags: short for the yellow phases and long for the green limits. Each phase change pulses the timer's restart strobe for one cycle. Both interval lengths are parameters counted in clock cycles. SHORT_CYC must be at least 2 and LONG_CYC must be greater than SHORT_CYC.

Top module: `tlc_junction`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the highway at green and the farm road at red from the next cycle, and restarts interval timing from that edge.
- R2: Each highway green phase, including the first one after reset, lasts at least LONG_CYC cycles.
- R3: The highway changes from green to yellow only after a cycle in which car_i was high and at least LONG_CYC-1 cycles of the phase had already passed. Otherwise it stays green.
- R4: The farm-road green phase ends after the first cycle in which car_i is low. If car_i stays high, it ends after exactly LONG_CYC cycles.
- R5: Every yellow phase, on either road, lasts exactly SHORT_CYC cycles.
- R6: Each road steps from green to yellow, from yellow to red and from red to green, and never in any other order.
- R7: The highway turns red in the same cycle as the farm road turns green. The farm road turns red in the same cycle as the highway turns green.
- R8: A restart strobe clears both timer flags at the next clock edge. The short flag is then first high SHORT_CYC cycles after the strobe cycle, and the long flag LONG_CYC cycles after it.
- R9: Light codes are green = 2'b00, yellow = 2'b01 and red = 2'b10. Code 2'b11 never appears, and in every cycle at least one road shows red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_i | input | 1 | Farm-road car waiting, synchronous |
| hwy_light_o | output | 2 | Highway colour code |
| farm_light_o | output | 2 | Farm-road colour code |

## Verification
Two functions can decide the same farm-green exit: the long-interval cap and the drop of car_i. The stimulus drops car_i in exactly the cycle in which the cap also expires, and also just before it and just after it. The result is judged on the length of that farm green and on the yellow that follows. The same kind of collision is provoked on the highway side by raising car_i in the last cycle of the minimum green. The behavioural reference model must then show the yellow starting on the next cycle, not one cycle later. A mid-run reset also lands on a phase change, to show that the reset takes priority over the advance.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    LT_GREEN  = 2'b00,
    LT_YELLOW = 2'b01,
    LT_RED    = 2'b10
  } light_t;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;
endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic short_done_o,
  output logic long_done_o
);
  localparam int CW = (LONG_CYC > 2) ? $clog2(LONG_CYC) : 1;
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  // counts edges since the restart edge, saturating at the long limit
  assign cnt_nx = (cnt_q >= LONG_M1) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q        <= '0;
      short_done_o <= 1'b0;
      long_done_o  <= 1'b0;
    end else begin
      cnt_q        <= cnt_nx;
      short_done_o <= (cnt_nx >= SHORT_M1);
      long_done_o  <= (cnt_nx >= LONG_M1);
    end
  end
endmodule

// File: rtl/tlc_phase_seq.sv
module tlc_phase_seq
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car_i,
  input  logic   short_done_i,
  input  logic   long_done_i,
  output phase_t phase_o,
  output logic   restart_o
);
  logic advance;

  always_comb begin
    unique case (phase_o)
      PH_HWY_GO:    advance = long_done_i && car_i;
      PH_HWY_WARN:  advance = short_done_i;
      PH_FARM_GO:   advance = long_done_i || !car_i;
      PH_FARM_WARN: advance = short_done_i;
      default:      advance = 1'b0;
    endcase
  end

  assign restart_o = advance && !rst;

  // modulo-4 phase counter, stepping only on a qualified trigger
  always_ff @(posedge clk) begin
    if (rst)          phase_o <= PH_HWY_GO;
    else if (advance) phase_o <= phase_t'(phase_o + 2'd1);
  end
endmodule

// File: rtl/tlc_light_dec.sv
module tlc_light_dec
  import tlc_pkg::*;
#(
  parameter bit FARM_SIDE = 1'b0
) (
  input  phase_t phase_i,
  output light_t light_o
);
  generate
    if (FARM_SIDE) begin : g_farm
      always_comb begin
        unique case (phase_i)
          PH_FARM_GO:   light_o = LT_GREEN;
          PH_FARM_WARN: light_o = LT_YELLOW;
          default:      light_o = LT_RED;
        endcase
      end
    end else begin : g_hwy
      always_comb begin
        unique case (phase_i)
          PH_HWY_GO:   light_o = LT_GREEN;
          PH_HWY_WARN: light_o = LT_YELLOW;
          default:     light_o = LT_RED;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/tlc_junction.sv
module tlc_junction
  import tlc_pkg::*;
#(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_i,
  output logic [1:0] hwy_light_o,
  output logic [1:0] farm_light_o
);
  logic   tmr_restart;
  logic   tmr_short;
  logic   tmr_long;
  phase_t phase;
  light_t hwy_l;
  light_t farm_l;

  tlc_interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) timer_i (
    .clk(clk), .rst(rst), .start_i(tmr_restart),
    .short_done_o(tmr_short), .long_done_o(tmr_long)
  );

  tlc_phase_seq seq_i (
    .clk(clk), .rst(rst), .car_i(car_i),
    .short_done_i(tmr_short), .long_done_i(tmr_long),
    .phase_o(phase), .restart_o(tmr_restart)
  );

  tlc_light_dec #(.FARM_SIDE(1'b0)) hwy_dec_i  (.phase_i(phase), .light_o(hwy_l));
  tlc_light_dec #(.FARM_SIDE(1'b1)) farm_dec_i (.phase_i(phase), .light_o(farm_l));

  assign hwy_light_o  = hwy_l;
  assign farm_light_o = farm_l;
endmodule

// File: rtl/tlc_junction_chk.sv
module tlc_junction_chk #(
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       car_i,
  input logic [1:0] hwy_light_o,
  input logic [1:0] farm_light_o,
  input logic       tmr_restart,
  input logic       tmr_short,
  input logic       tmr_long
);
  localparam logic [1:0] G = 2'b00;
  localparam logic [1:0] Y = 2'b01;
  localparam logic [1:0] R = 2'b10;

  logic yel_now;
  int   ycnt;
  int   gcnt;

  assign yel_now = (hwy_light_o == Y) || (farm_light_o == Y);

  always_ff @(posedge clk) begin
    if (rst) begin
      ycnt <= 0;
      gcnt <= 0;
    end else begin
      ycnt <= yel_now ? ycnt + 1 : 0;
      if (hwy_light_o == G) gcnt <= (gcnt < LONG_CYC) ? gcnt + 1 : gcnt;
      else                  gcnt <= 0;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hwy_light_o == G && farm_light_o == R)); // R1
  AST_HWY_MIN_GREEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hwy_light_o) == G && hwy_light_o != G) |-> (gcnt >= LONG_CYC)); // R2
  AST_HWY_LEAVE_ON_CAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hwy_light_o) == G && hwy_light_o == Y) |-> $past(car_i)); // R3
  AST_FARM_CUT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(farm_light_o) == G && !$past(car_i)) |-> (farm_light_o == Y)); // R4
  AST_YELLOW_LEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(yel_now) && !yel_now) |-> (ycnt == SHORT_CYC)); // R5
  AST_HWY_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hwy_light_o != $past(hwy_light_o)) |->
      (($past(hwy_light_o) == G && hwy_light_o == Y) || ($past(hwy_light_o) == Y && hwy_light_o == R) ||
       ($past(hwy_light_o) == R && hwy_light_o == G))); // R6
  AST_FARM_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && farm_light_o != $past(farm_light_o)) |->
      (($past(farm_light_o) == G && farm_light_o == Y) || ($past(farm_light_o) == Y && farm_light_o == R) ||
       ($past(farm_light_o) == R && farm_light_o == G))); // R6
  AST_HANDOFF_TO_FARM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hwy_light_o == R && $past(hwy_light_o) != R) |-> (farm_light_o == G && $past(farm_light_o) == R)); // R7
  AST_HANDOFF_TO_HWY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && farm_light_o == R && $past(farm_light_o) != R) |-> (hwy_light_o == G && $past(hwy_light_o) == R)); // R7
  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmr_restart)) |-> (!tmr_short && !tmr_long)); // R8
  AST_ONE_ROAD_RED: assert property (@(posedge clk) disable iff (rst)
    (hwy_light_o == R || farm_light_o == R) && hwy_light_o != 2'b11 && farm_light_o != 2'b11); // R9
endmodule

bind tlc_junction tlc_junction_chk #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) chk_i (
  .clk(clk), .rst(rst), .car_i(car_i),
  .hwy_light_o(hwy_light_o), .farm_light_o(farm_light_o),
  .tmr_restart(tmr_restart), .tmr_short(tmr_short), .tmr_long(tmr_long)
);

// File: tb/tlc_junction_tb_top.sv
module tlc_junction_tb_top;
  localparam int SHORT = 3;
  localparam int LONG  = 8;
  localparam int END_CYC = 420;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car = 1'b0;
  logic [1:0] hwy;
  logic [1:0] farm;

  int tests  = 0;
  int fails  = 0;
  int cyc    = 0;
  int ph     = 0;   // model phase: 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
  int t      = 0;   // cycles already spent in phase
  bit done   = 0;

  always #2 clk = ~clk;

  tlc_junction #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut_i (
    .clk(clk), .rst(rst), .car_i(car), .hwy_light_o(hwy), .farm_light_o(farm)
  );

  function automatic logic car_at(int c);
    if (c < 30)  return 1'b0;            // hwy holds green with no car (R3)
    if (c < 90)  return 1'b1;            // continuous cars: farm green capped (R4)
    if (c < 120) return 1'b0;
    if (c < 200) return (c % 7) < 4;     // short bursts cut farm green (R4)
    if (c < 260) return (c % 11) != 0;
    if (c < 330) return (c % 13) < 9;
    return (c % 3) == 0;
  endfunction

  function automatic logic [1:0] exp_hwy(int p);
    return (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : 2'b10;
  endfunction
  function automatic logic [1:0] exp_farm(int p);
    return (p == 2) ? 2'b00 : (p == 3) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string rq;
      bit adv;
      logic nrst;
      case (ph)
        0: rq = "R2 R3";
        1: rq = "R5 R8";
        2: rq = "R4 R7";
        default: rq = "R5 R6";
      endcase
      if (cyc < 3) rq = "R1";
      check({rq, " hwy"}, hwy, exp_hwy(ph));
      check({rq, " farm"}, farm, exp_farm(ph));
      tests++;
      if (!(hwy == 2'b10 || farm == 2'b10)) begin
        fails++;
        $display("FAIL R9 cyc=%0d actual=%b/%b expected one road red", cyc, hwy, farm);
      end
      // drive inputs for the coming edge, then step the model
      nrst = (cyc < 2) || (cyc >= 300 && cyc < 302);
      car  = car_at(cyc);
      rst  = nrst;
      case (ph)
        0: adv = (t >= LONG - 1) && car;
        1: adv = (t >= SHORT - 1);
        2: adv = (t >= LONG - 1) || !car;
        default: adv = (t >= SHORT - 1);
      endcase
      if (nrst) begin
        ph = 0; t = 0;
      end else if (adv) begin
        ph = (ph + 1) % 4; t = 0;
      end else begin
        t++;
      end
      cyc++;
      if (cyc == END_CYC) begin
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule